// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is an 8-bit control register that sits on a microcontroller's peripheral bus and drives its power-management logic. Software writes one byte to request entry into one of three low-power modes (sleep, stop, or timer-only operation). The same byte can start an internal reset pulse of fixed length, choose whether pads float while the chip is powered down, and choose how many clock pulses the CPU is held on each bus access when the CPU runs intermittently.

The mode-request bits and the reset bit act only on a write of 1 and are never stored, so a read returns 0 in those positions. The pad-float bit, the two halt-length bits and a reserved bit are stored and can be read back. A CPU access strobe loads a down-counter from the halt-length setting. The counter holds a halt-enable output high for that many clock cycles, and the clock generator outside the block uses it to gate the CPU clock. The block only produces requests and enables. Oscillator control, wake-up and the pad drivers are outside it.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While `rst` is high and after it falls, all request outputs, `irst_out`, `cpu_halt` and `pad_float` are 0, and a read returns 8'h00.
- R2: A read (`bus_rd` high for one cycle) returns data on `bus_rdata` in the next cycle. Bits 5 (pad float), 2:1 (halt length) and 0 (reserved) return their stored values. Bits 7, 6, 4 and 3 always return 0.
- R3: A write with bit 7 set produces `req_stop` high for exactly the one cycle after the write. Writes with bit 7 clear never raise it.
- R4: A write with bit 3 set raises `req_tbt`, and a write with bit 6 set raises `req_sleep`. Each is a one-cycle pulse in the cycle after the write. A 0 in these bits has no effect.
- R5: When one write sets several mode bits, the priority is stop over timer mode (bit 3), and timer mode over sleep (bit 6). Only the winning request pulses, so at most one request output is high in any cycle.
- R6: A write with bit 4 set drives `irst_out` high for exactly 3 machine cycles (one clock cycle each by default), starting the cycle after the write.
- R7: A bit-4 write that arrives while `irst_out` is high is ignored, and the pulse is not extended. A bit-4 write after the pulse has ended starts a new full pulse.
- R8: `pad_float` follows the stored bit 5 from the cycle after the write. 1 means the pads float in stop and timer modes, and 0 means they keep their state.
- R9: The halt-length code in bits 2:1 selects 0, 9, 17 or 33 cycles for codes 00, 01, 10 and 11. After a `cpu_acc` strobe, `cpu_halt` is high for exactly that many cycles, starting the cycle after the strobe.
- R10: With code 00, `cpu_halt` never rises. A `cpu_acc` strobe while `cpu_halt` is high is ignored, and the run is not lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| cpu_acc | input | 1 | CPU bus access strobe, starts a halt run |
| req_stop | output | 1 | One-cycle stop-mode request |
| req_sleep | output | 1 | One-cycle sleep-mode request |
| req_tbt | output | 1 | One-cycle timer-only mode request |
| pad_float | output | 1 | Pad float select for stop and timer modes |
| irst_out | output | 1 | Internal reset pulse |
| cpu_halt | output | 1 | CPU clock halt enable |

## Verification
Checks that run on every cycle cover three things: at most one mode request is active, each request pulse traces back to a write with its bit set, and the read data never shows a write-only bit. They also check that every reset pulse and every halt run lasts exactly its programmed length, and that code 00 never starts a halt. The bench scenarios cover the rest. They exercise all 256 write values through the priority and readback paths, and they confirm that the numeric lengths 0, 9, 17 and 33 match the codes. They also show that a second reset request or a second access strobe during an active run does not extend it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_W     = 8;
  localparam int B_STOP    = 7;
  localparam int B_SLEEP   = 6;
  localparam int B_PADF    = 5;
  localparam int B_IRST    = 4;
  localparam int B_TBT     = 3;
  localparam int B_HSEL_HI = 2;
  localparam int B_HSEL_LO = 1;
  localparam int B_RSV     = 0;
  localparam logic [REG_W-1:0] RD_MASK = 8'h27;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_SLEEP = 2'd1,
    WIN_TBT   = 2'd2,
    WIN_STOP  = 2'd3
  } mode_win_e;
endpackage

// File: rtl/pmc_req_arb.sv
module pmc_req_arb
  import pmc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic want_stop,
  input  logic want_sleep,
  input  logic want_tbt,
  output logic req_stop,
  output logic req_sleep,
  output logic req_tbt
);
  mode_win_e win;

  always_comb begin
    win = WIN_NONE;
    if (wr_stb) begin
      if (want_stop)       win = WIN_STOP;
      else if (want_tbt)   win = WIN_TBT;
      else if (want_sleep) win = WIN_SLEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_stop  <= 1'b0;
      req_sleep <= 1'b0;
      req_tbt   <= 1'b0;
    end else begin
      req_stop  <= (win == WIN_STOP);
      req_sleep <= (win == WIN_SLEEP);
      req_tbt   <= (win == WIN_TBT);
    end
  end

  assert_stop_cause_R3: assert property (@(posedge clk) disable iff (rst)
    req_stop |-> $past(wr_stb && want_stop));
  assert_tbt_cause_R4: assert property (@(posedge clk) disable iff (rst)
    req_tbt |-> $past(wr_stb && want_tbt && !want_stop));
  assert_sleep_cause_R5: assert property (@(posedge clk) disable iff (rst)
    req_sleep |-> $past(wr_stb && want_sleep && !want_stop && !want_tbt));
endmodule

// File: rtl/pmc_rst_gen.sv
module pmc_rst_gen #(
  parameter int RST_MCYC = 3,
  parameter int MC_CLKS  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic irst_out
);
  localparam int TOTAL = RST_MCYC * MC_CLKS;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (trig) begin
      cnt <= CW'(TOTAL);
    end
  end

  assign irst_out = (cnt != '0);

  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)           run_len <= '0;
    else if (irst_out) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(irst_out) |-> (run_len == (CW+1)'(TOTAL)));
  assert_no_extend_R7: assert property (@(posedge clk) disable iff (rst)
    run_len <= (CW+1)'(TOTAL));
endmodule

// File: rtl/pmc_halt_cnt.sv
module pmc_halt_cnt #(
  parameter int SEL_W = 2,
  parameter int SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             acc,
  output logic             halt
);
  localparam int MAXN = (1 << ((1 << SEL_W) - 1 + SHIFT)) + 1;
  localparam int CW   = $clog2(MAXN + 1);

  logic [CW-1:0] load_n;
  logic [CW-1:0] cnt;

  always_comb begin
    int tmp;
    tmp = (1 << (int'(sel) + SHIFT)) + 1;
    load_n = (sel == '0) ? '0 : CW'(tmp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (acc) begin
      cnt <= load_n;
    end
  end

  assign halt = (cnt != '0);

  logic [CW:0] hrun;
  logic [CW:0] lat_n;
  always_ff @(posedge clk) begin
    if (rst) begin
      hrun  <= '0;
      lat_n <= '0;
    end else begin
      hrun <= halt ? hrun + 1'b1 : '0;
      if (acc && !halt) lat_n <= {1'b0, load_n};
    end
  end

  assert_halt_len_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(halt) |-> (hrun == lat_n));
  assert_zero_code_R10: assert property (@(posedge clk) disable iff (rst)
    (acc && !halt && sel == '0) |=> !halt);
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pmc_pkg::*;
#(
  parameter int RST_MCYC   = 3,
  parameter int MC_CLKS    = 1,
  parameter int HALT_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             cpu_acc,
  output logic             req_stop,
  output logic             req_sleep,
  output logic             req_tbt,
  output logic             pad_float,
  output logic             irst_out,
  output logic             cpu_halt
);
  localparam int SEL_W = B_HSEL_HI - B_HSEL_LO + 1;

  logic             padf_q;
  logic [SEL_W-1:0] hsel_q;
  logic             rsv_q;
  logic [REG_W-1:0] rd_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      padf_q <= 1'b0;
      hsel_q <= '0;
      rsv_q  <= 1'b0;
    end else if (bus_wr) begin
      padf_q <= bus_wdata[B_PADF];
      hsel_q <= bus_wdata[B_HSEL_HI:B_HSEL_LO];
      rsv_q  <= bus_wdata[B_RSV];
    end
  end

  always_comb begin
    rd_view = '0;
    rd_view[B_PADF]              = padf_q;
    rd_view[B_HSEL_HI:B_HSEL_LO] = hsel_q;
    rd_view[B_RSV]               = rsv_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_view;
  end

  assign pad_float = padf_q;

  pmc_req_arb u_arb (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (bus_wr),
    .want_stop  (bus_wdata[B_STOP]),
    .want_sleep (bus_wdata[B_SLEEP]),
    .want_tbt   (bus_wdata[B_TBT]),
    .req_stop   (req_stop),
    .req_sleep  (req_sleep),
    .req_tbt    (req_tbt)
  );

  pmc_rst_gen #(
    .RST_MCYC (RST_MCYC),
    .MC_CLKS  (MC_CLKS)
  ) u_rst (
    .clk      (clk),
    .rst      (rst),
    .trig     (bus_wr && bus_wdata[B_IRST]),
    .irst_out (irst_out)
  );

  pmc_halt_cnt #(
    .SEL_W (SEL_W),
    .SHIFT (HALT_SHIFT)
  ) u_halt (
    .clk  (clk),
    .rst  (rst),
    .sel  (hsel_q),
    .acc  (cpu_acc),
    .halt (cpu_halt)
  );

  assert_req_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_stop, req_sleep, req_tbt}));
  assert_wo_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> ((bus_rdata & ~RD_MASK) == '0));
  assert_padf_follow_R8: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> (pad_float == $past(bus_wdata[B_PADF])));
endmodule

// File: tb/pwr_mode_ctl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, cpu_acc = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       req_stop, req_sleep, req_tbt, pad_float, irst_out, cpu_halt;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctl u_pwr_mode_ctl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_acc(cpu_acc),
    .req_stop(req_stop), .req_sleep(req_sleep), .req_tbt(req_tbt),
    .pad_float(pad_float), .irst_out(irst_out), .cpu_halt(cpu_halt)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic do_read(output logic [7:0] r);
    @(negedge clk); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; r = bus_rdata;
  endtask

  task automatic halt_run(input bit restrobe, output int len);
    @(negedge clk); cpu_acc = 1'b1;
    @(negedge clk); cpu_acc = 1'b0;
    len = 0;
    while (cpu_halt && len < 100) begin
      len++;
      cpu_acc = (restrobe && len == 3);
      @(negedge clk);
    end
    cpu_acc = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int len;
    repeat (4) @(negedge clk);
    // R1: state during and after reset
    check("R1 irst_out in reset", irst_out, 0);
    check("R1 cpu_halt in reset", cpu_halt, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 requests", {req_stop, req_sleep, req_tbt}, 0);
    check("R1 pad_float", pad_float, 0);
    check("R1 irst_out", irst_out, 0);
    do_read(rd);
    check("R1 readback", rd, 0);

    // Exhaustive write sweep: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      bit es, et, el;
      b  = 8'(v);
      es = b[7];
      et = b[3] && !b[7];
      el = b[6] && !b[7] && !b[3];
      do_write(b);
      check("R3 stop pulse", req_stop, es);
      check("R4 tbt pulse", req_tbt, et);
      check("R5 sleep after priority", req_sleep, el);
      check("R6 irst first cycle", irst_out, b[4]);
      check("R8 pad_float", pad_float, b[5]);
      @(negedge clk);
      check("R3 R4 pulse width one", {req_stop, req_sleep, req_tbt}, 0);
      check("R6 irst second cycle", irst_out, b[4]);
      @(negedge clk);
      check("R6 irst third cycle", irst_out, b[4]);
      @(negedge clk);
      check("R6 irst ended", irst_out, 0);
      do_read(rd);
      check("R2 readback mask", rd, int'(b & 8'h27));
    end

    // R7: second reset request during an active pulse
    @(negedge clk); bus_wr = 1'b1; bus_wdata = 8'h11;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b0; bus_wdata = 8'h00;
    len = 0;
    for (int i = 0; i < 8; i++) begin
      if (irst_out) len++;
      @(negedge clk);
    end
    check("R7 pulse not extended", len + 1, 3);
    do_write(8'h11);
    len = 0;
    for (int i = 0; i < 8; i++) begin
      if (irst_out) len++;
      @(negedge clk);
    end
    check("R7 new pulse after end", len, 3);

    // R9 R10: halt lengths for every code
    for (int c = 0; c < 4; c++) begin
      int exp_len;
      exp_len = (c == 0) ? 0 : (1 << (c + 2)) + 1;
      do_write(8'((c << 1) | 1));
      halt_run(1'b0, len);
      check("R9 halt length", len, exp_len);
      halt_run(1'b1, len);
      check("R10 restrobe ignored", len, exp_len);
      if (c == 0) begin
        bit seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
          @(negedge clk); cpu_acc = 1'b1;
          if (cpu_halt) seen = 1'b1;
        end
        @(negedge clk); cpu_acc = 1'b0;
        if (cpu_halt) seen = 1'b1;
        check("R10 code zero never halts", seen, 0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule